// File: doc/BRIEF.md
# Pin Boundary-Scan Chain

This block is the boundary-scan register that sits between a device's core logic and its pads. It has a parameterised count of output pins and input pins. Every output pin has two scan cells: one holds the driven value and one holds the drive enable. Every input pin has one scan cell. Each cell pairs a shift flip-flop with an update latch. The test controller supplies single-cycle capture, shift and update strobes, together with a mode code that names the active test instruction.

In sample/preload and in functional mode, the core drives the pads unchanged, and the chain can still capture pad activity and preload the latches. In external-test mode, the update latches drive the pads, and the input latches feed the core. In clamp mode the latched pad state is held while the scan path collapses to a single bypass stage. In high-impedance mode every output enable is forced off and the bypass stage is used. The pad-side outputs are registered, so they follow their sources one clock later.

Top module: `scan_chain`

## Requirements
- R1: In sample/preload (mode 1) and external-test (mode 2), the path from scan_in to scan_out is 2*N_OUT+N_IN stages long and advances one bit per clock while shift is high. A capture strobe in the same clock takes priority over shift.
- R2: Chain position 0 is nearest scan_in. For output k, the value cell is at position 2k and the enable cell is at 2k+1, so the value cell lies nearer scan_in. Input j is at position 2*N_OUT+j. After a capture, the cell at the highest position appears on scan_out first.
- R3: When capture is high in mode 1 or 2, each output value cell loads the current pad_out_val bit and each enable cell loads the current pad_out_oe bit. Each input cell loads the pad_in bit.
- R4: An update strobe copies every shift flip-flop into its latch only in modes 1 and 2. In every other mode, update and shift leave the latches unchanged.
- R5: In functional mode (0), in sample/preload (1) and for the unused codes 5 to 7, pad_out_val and pad_out_oe equal core_out_val and core_out_oe of the previous clock.
- R6: In external-test mode (2), pad_out_val[k] takes latch 2k and pad_out_oe[k] takes latch 2k+1. core_in[j] takes latch 2*N_OUT+j. All three follow one clock after the latch.
- R7: In clamp mode (3), the pads take their value and enable from the latches. scan_in reaches scan_out through one bypass stage, and a capture loads that stage with 0.
- R8: In high-impedance mode (4), every pad_out_oe bit is 0 from the next clock on, and pad_out_val takes the value latches. The scan path is the bypass stage.
- R9: While rst is high at a clock edge, scan_out, pad_out_val, pad_out_oe, core_in and all latches become 0.
- R10: In every mode except 2, core_in equals pad_in of the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Instruction code: 0 functional, 1 sample/preload, 2 external test, 3 clamp, 4 high-impedance |
| capture | input | 1 | Capture strobe |
| shift | input | 1 | Shift strobe |
| update | input | 1 | Update strobe |
| scan_in | input | 1 | Serial data in |
| scan_out | output | 1 | Serial data out |
| core_out_val | input | N_OUT | Output values from the core |
| core_out_oe | input | N_OUT | Output enables from the core (1 = drive) |
| core_in | output | N_IN | Input values delivered to the core |
| pad_out_val | output | N_OUT | Value to the output pads |
| pad_out_oe | output | N_OUT | Drive enable to the output pads |
| pad_in | input | N_IN | Values from the input pads |

## Verification
The chain is scanned with distinct non-symmetric vectors in sample/preload and in external test. The captured bits come from different sources in the two runs: core-driven pads in the first and latch-driven pads in the second. This separates a swapped value/enable cell, a reversed chain and a wrong capture source. The same kind of scan repeated in clamp and high-impedance modes shows a one-bit delay on scan_out, and this separates the bypass path from the full chain. The pad state read back afterwards shows that those updates had no effect. Unused mode codes and functional mode are set against differing core and latch contents to confirm the pass-through.

// File: rtl/scan_chain_pkg.sv
package scan_chain_pkg;

  typedef enum logic [2:0] {
    MODE_FUNC   = 3'd0,
    MODE_SAMPLE = 3'd1,
    MODE_EXTEST = 3'd2,
    MODE_CLAMP  = 3'd3,
    MODE_HIGHZ  = 3'd4
  } scan_mode_e;

  function automatic logic chain_selected(input logic [2:0] m);
    return (m == MODE_SAMPLE) || (m == MODE_EXTEST);
  endfunction

endpackage

// File: rtl/scan_cell.sv
module scan_cell (
  input  logic clk,
  input  logic rst,
  input  logic cap_en,
  input  logic shift_en,
  input  logic upd_en,
  input  logic cap_d,
  input  logic ser_in,
  output logic ser_q,
  output logic upd_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_q <= 1'b0;
    end else if (cap_en) begin
      ser_q <= cap_d;
    end else if (shift_en) begin
      ser_q <= ser_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_q <= 1'b0;
    end else if (upd_en) begin
      upd_q <= ser_q;
    end
  end

endmodule

// File: rtl/scan_bypass.sv
module scan_bypass (
  input  logic clk,
  input  logic rst,
  input  logic cap_en,
  input  logic shift_en,
  input  logic ser_in,
  output logic ser_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_q <= 1'b0;
    end else if (cap_en) begin
      ser_q <= 1'b0;
    end else if (shift_en) begin
      ser_q <= ser_in;
    end
  end

endmodule

// File: rtl/pad_steer.sv
module pad_steer
  import scan_chain_pkg::*;
#(
  parameter int N_OUT = 4,
  parameter int N_IN  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode,
  input  logic [N_OUT-1:0] core_out_val,
  input  logic [N_OUT-1:0] core_out_oe,
  input  logic [N_OUT-1:0] lat_val,
  input  logic [N_OUT-1:0] lat_oe,
  input  logic [N_IN-1:0]  lat_in,
  input  logic [N_IN-1:0]  pad_in,
  output logic [N_OUT-1:0] pad_out_val,
  output logic [N_OUT-1:0] pad_out_oe,
  output logic [N_IN-1:0]  core_in
);

  logic [N_OUT-1:0] nxt_val;
  logic [N_OUT-1:0] nxt_oe;
  logic [N_IN-1:0]  nxt_in;

  always_comb begin
    nxt_val = core_out_val;
    nxt_oe  = core_out_oe;
    nxt_in  = pad_in;
    case (scan_mode_e'(mode))
      MODE_EXTEST: begin
        nxt_val = lat_val;
        nxt_oe  = lat_oe;
        nxt_in  = lat_in;
      end
      MODE_CLAMP: begin
        nxt_val = lat_val;
        nxt_oe  = lat_oe;
      end
      MODE_HIGHZ: begin
        nxt_val = lat_val;
        nxt_oe  = '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out_val <= '0;
      pad_out_oe  <= '0;
      core_in     <= '0;
    end else begin
      pad_out_val <= nxt_val;
      pad_out_oe  <= nxt_oe;
      core_in     <= nxt_in;
    end
  end

endmodule

// File: rtl/scan_chain.sv
module scan_chain
  import scan_chain_pkg::*;
#(
  parameter int N_OUT = 4,
  parameter int N_IN  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode,
  input  logic             capture,
  input  logic             shift,
  input  logic             update,
  input  logic             scan_in,
  output logic             scan_out,
  input  logic [N_OUT-1:0] core_out_val,
  input  logic [N_OUT-1:0] core_out_oe,
  output logic [N_IN-1:0]  core_in,
  output logic [N_OUT-1:0] pad_out_val,
  output logic [N_OUT-1:0] pad_out_oe,
  input  logic [N_IN-1:0]  pad_in
);

  localparam int LEN      = 2 * N_OUT + N_IN;
  localparam int IN_BASE  = 2 * N_OUT;

  logic             chain_sel;
  logic             cell_cap;
  logic             cell_shift;
  logic             cell_upd;
  logic             byp_cap;
  logic             byp_shift;
  logic             byp_q;
  logic [LEN:0]     link;
  logic [LEN-1:0]   cap_vec;
  logic [LEN-1:0]   upd_vec;
  logic [N_OUT-1:0] lat_val;
  logic [N_OUT-1:0] lat_oe;
  logic [N_IN-1:0]  lat_in;

  assign chain_sel  = chain_selected(mode);
  assign cell_cap   = capture & chain_sel;
  assign cell_shift = shift & chain_sel;
  assign cell_upd   = update & chain_sel;
  assign byp_cap    = capture & ~chain_sel;
  assign byp_shift  = shift & ~chain_sel;
  assign link[0]    = scan_in;

  // Capture sources and latch fan-out: value cell nearer scan_in, then enable cell
  for (genvar k = 0; k < N_OUT; k++) begin : g_out_map
    assign cap_vec[2*k]   = pad_out_val[k];
    assign cap_vec[2*k+1] = pad_out_oe[k];
    assign lat_val[k]     = upd_vec[2*k];
    assign lat_oe[k]      = upd_vec[2*k+1];
  end

  for (genvar j = 0; j < N_IN; j++) begin : g_in_map
    assign cap_vec[IN_BASE+j] = pad_in[j];
    assign lat_in[j]          = upd_vec[IN_BASE+j];
  end

  for (genvar i = 0; i < LEN; i++) begin : g_cell
    scan_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .cap_en   (cell_cap),
      .shift_en (cell_shift),
      .upd_en   (cell_upd),
      .cap_d    (cap_vec[i]),
      .ser_in   (link[i]),
      .ser_q    (link[i+1]),
      .upd_q    (upd_vec[i])
    );
  end

  scan_bypass u_bypass (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (byp_cap),
    .shift_en (byp_shift),
    .ser_in   (scan_in),
    .ser_q    (byp_q)
  );

  assign scan_out = chain_sel ? link[LEN] : byp_q;

  pad_steer #(
    .N_OUT (N_OUT),
    .N_IN  (N_IN)
  ) u_steer (
    .clk          (clk),
    .rst          (rst),
    .mode         (mode),
    .core_out_val (core_out_val),
    .core_out_oe  (core_out_oe),
    .lat_val      (lat_val),
    .lat_oe       (lat_oe),
    .lat_in       (lat_in),
    .pad_in       (pad_in),
    .pad_out_val  (pad_out_val),
    .pad_out_oe   (pad_out_oe),
    .core_in      (core_in)
  );

endmodule

// File: rtl/scan_chain_chk.sv
module scan_chain_chk #(
  parameter int N_OUT = 4,
  parameter int N_IN  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       mode,
  input logic             capture,
  input logic             shift,
  input logic             scan_in,
  input logic             scan_out,
  input logic [N_OUT-1:0] core_out_val,
  input logic [N_OUT-1:0] core_out_oe,
  input logic [N_IN-1:0]  core_in,
  input logic [N_OUT-1:0] pad_out_val,
  input logic [N_OUT-1:0] pad_out_oe,
  input logic [N_IN-1:0]  pad_in
);

  AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((mode == 3'd1 || mode == 3'd2) && !shift && !capture) ##1 (mode == 3'd1 || mode == 3'd2)
      |-> $stable(scan_out)); // R1

  AST_SAMPLE_PASS: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd1) |=> (pad_out_val == $past(core_out_val) && pad_out_oe == $past(core_out_oe))); // R5

  AST_CLAMP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd3) ##1 (mode == 3'd3) |=> ($stable(pad_out_val) && $stable(pad_out_oe))); // R7

  AST_BYPASS_ONE: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd3 && shift && !capture) ##1 (mode == 3'd3) |-> (scan_out == $past(scan_in))); // R7

  AST_HIGHZ_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd4) |=> (pad_out_oe == '0)); // R8

  AST_CORE_IN_PASS: assert property (@(posedge clk) disable iff (rst)
    (mode != 3'd2) |=> (core_in == $past(pad_in))); // R10

endmodule

bind scan_chain scan_chain_chk #(.N_OUT(N_OUT), .N_IN(N_IN)) u_chk (.*);

// File: tb/sim_scan_chain.sv
module sim_scan_chain;

  localparam int N_OUT = 4;
  localparam int N_IN  = 4;
  localparam int LEN   = 2 * N_OUT + N_IN;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       mode = 3'd0;
  logic             capture = 1'b0;
  logic             shift = 1'b0;
  logic             update = 1'b0;
  logic             scan_in = 1'b0;
  logic             scan_out;
  logic [N_OUT-1:0] core_out_val = '0;
  logic [N_OUT-1:0] core_out_oe = '0;
  logic [N_IN-1:0]  core_in;
  logic [N_OUT-1:0] pad_out_val;
  logic [N_OUT-1:0] pad_out_oe;
  logic [N_IN-1:0]  pad_in = '0;

  int checks = 0;
  int fails  = 0;

  logic [LEN-1:0] lat = '0;
  logic           exp_q[$];
  string          tag_q[$];
  logic           mon_on = 1'b0;
  logic           mon_e;
  string          mon_t;

  always #5 clk = ~clk;

  scan_chain #(.N_OUT(N_OUT), .N_IN(N_IN)) u0 (
    .clk(clk), .rst(rst), .mode(mode), .capture(capture), .shift(shift),
    .update(update), .scan_in(scan_in), .scan_out(scan_out),
    .core_out_val(core_out_val), .core_out_oe(core_out_oe), .core_in(core_in),
    .pad_out_val(pad_out_val), .pad_out_oe(pad_out_oe), .pad_in(pad_in)
  );

  // Monitor: pops expected serial bits and compares scan_out
  always @(negedge clk) begin
    #2;
    if (mon_on && exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      mon_t = tag_q.pop_front();
      checks++;
      if (scan_out !== mon_e) begin
        fails++;
        $display("FAIL %s scan_out got %0b expected %0b", mon_t, scan_out, mon_e);
      end
    end
  end

  function automatic logic [N_OUT-1:0] exp_val();
    logic [N_OUT-1:0] r;
    for (int k = 0; k < N_OUT; k++)
      r[k] = (mode == 3'd2 || mode == 3'd3 || mode == 3'd4) ? lat[2*k] : core_out_val[k];
    return r;
  endfunction

  function automatic logic [N_OUT-1:0] exp_oe();
    logic [N_OUT-1:0] r;
    for (int k = 0; k < N_OUT; k++)
      r[k] = (mode == 3'd4) ? 1'b0 :
             (mode == 3'd2 || mode == 3'd3) ? lat[2*k+1] : core_out_oe[k];
    return r;
  endfunction

  function automatic logic [N_IN-1:0] exp_core_in();
    logic [N_IN-1:0] r;
    for (int j = 0; j < N_IN; j++)
      r[j] = (mode == 3'd2) ? lat[2*N_OUT+j] : pad_in[j];
    return r;
  endfunction

  task automatic check1(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic check_pads(input string tag);
    repeat (2) @(negedge clk);
    #2;
    check1({tag, " pad_out_val"}, 32'(pad_out_val), 32'(exp_val()));
    check1({tag, " pad_out_oe"},  32'(pad_out_oe),  32'(exp_oe()));
    check1({tag, " core_in"},     32'(core_in),     32'(exp_core_in()));
  endtask

  // Driver: capture, shift LEN bits of v (v[i] lands in position i), optional update
  task automatic run_scan(input logic [LEN-1:0] v, input string tag, input bit do_upd);
    logic [LEN-1:0] cap;
    bit chain;
    chain = (mode == 3'd1 || mode == 3'd2);
    for (int k = 0; k < N_OUT; k++) begin
      cap[2*k]   = exp_val()[k];
      cap[2*k+1] = exp_oe()[k];
    end
    for (int j = 0; j < N_IN; j++) cap[2*N_OUT+j] = pad_in[j];
    @(negedge clk);
    capture = 1'b1;
    @(negedge clk);
    capture = 1'b0;
    shift   = 1'b1;
    for (int k = 0; k < LEN; k++) begin
      scan_in = v[LEN-1-k];
      if (chain) exp_q.push_back(cap[LEN-1-k]);
      else       exp_q.push_back((k == 0) ? 1'b0 : v[LEN-k]);
      tag_q.push_back(tag);
      mon_on = 1'b1;
      @(negedge clk);
    end
    shift  = 1'b0;
    mon_on = 1'b0;
    if (do_upd) begin
      update = 1'b1;
      @(negedge clk);
      update = 1'b0;
      if (chain) lat = v;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    core_out_val = 4'b1011;
    core_out_oe  = 4'b1101;
    pad_in       = 4'b0111;
    repeat (3) @(negedge clk);
    #2;
    check1("R9 reset pad_out_val", 32'(pad_out_val), 0);
    check1("R9 reset pad_out_oe", 32'(pad_out_oe), 0);
    check1("R9 reset core_in", 32'(core_in), 0);
    check1("R9 reset scan_out", 32'(scan_out), 0);
    rst = 1'b0;

    mode = 3'd0;
    check_pads("R5 R10 functional pass-through");

    mode = 3'd1;
    check_pads("R5 sample pass-through");
    run_scan(12'b1001_1010_0110, "R1 R2 R3 sample capture", 1'b1);
    check_pads("R5 sample after update");

    mode = 3'd2;
    check_pads("R6 extest drives latches");
    core_out_val = 4'b0100;
    pad_in       = 4'b1010;
    run_scan(12'b0110_0101_1100, "R1 R2 R3 extest capture", 1'b1);
    check_pads("R6 extest new latches");

    mode = 3'd3;
    check_pads("R7 clamp holds latches");
    run_scan(12'b1111_0000_1010, "R7 clamp bypass", 1'b1);
    check_pads("R4 clamp update ignored");

    mode = 3'd4;
    check_pads("R8 highz enables off");
    run_scan(12'b0011_1100_0101, "R8 highz bypass", 1'b1);
    check_pads("R8 R4 highz update ignored");

    mode = 3'd2;
    check_pads("R4 extest latches unchanged");

    mode = 3'd6;
    core_out_oe = 4'b0011;
    check_pads("R5 unused code passes core");

    mode = 3'd0;
    run_scan(12'b1010_1010_1010, "R4 functional bypass", 1'b1);
    mode = 3'd2;
    check_pads("R4 functional update ignored");

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule